// File: doc/BRIEF.md
# Packed Half-to-Single Widening Converter

This block widens a vector of IEEE 754 binary16 values into binary32 values in a single registered step. A 256-bit source carries sixteen 16-bit lanes. Lane j of the source, bits [16j+15:16j], becomes lane j of a 512-bit result, bits [32j+31:32j]. A vector-length select limits the work to the low 4, 8 or 16 lanes. Every result bit above the chosen length is cleared.

Per-lane writemasking is optional. When it is enabled, a lane whose mask bit is clear is not converted. In merge mode that lane keeps its previous destination value, which the caller supplies on a separate 512-bit input. In zeroing mode that lane is cleared. Binary16 subnormals are always normalized exactly into binary32. The block has no flush-to-zero control and reports no denormal condition. The only exception it reports is invalid operation, raised by a signalling NaN on a lane that is written. That flag is sticky until reset.

The control is a two-state machine. `ST_IDLE` waits for input. The transition `T_ACCEPT` (ST_IDLE to ST_EMIT, on `in_valid`) captures a result. `ST_EMIT` presents that result with `out_valid` high for the cycle. From ST_EMIT, `T_CHAIN` (ST_EMIT to ST_EMIT, on `in_valid`) captures the next result back to back. `T_RETIRE` (ST_EMIT to ST_IDLE, without `in_valid`) returns to waiting. In ST_IDLE with no input, `T_WAIT` keeps the machine idle.

Top module: `fp16_widen_unit`

## Requirements
- R1: A normal binary16 input (exponent field 1..30) converts as follows: the sign is copied, the 5-bit exponent plus 112 becomes the 8-bit exponent, and the 10-bit fraction fills result bits [22:13] with bits [12:0] zero. Source lane j maps to result lane j.
- R2: A binary16 zero (exponent 0, fraction 0) yields a binary32 zero of the same sign. Infinity (exponent 31, fraction 0) yields exponent 255 with a zero fraction and the same sign.
- R3: A binary16 subnormal (exponent 0, fraction nonzero) yields the exactly equal normalized binary32 value. The conversion is never flushed to zero.
- R4: A NaN input (exponent 31, fraction nonzero) yields exponent 255 with result bit 22 forced to 1, result bits [21:13] equal to input fraction bits [8:0], result bits [12:0] zero, and the sign copied.
- R5: `vlen_sel` picks the active lanes: 0 selects lanes 0..3 (128 bits), 1 selects lanes 0..7 (256 bits), and 2 or 3 selects all 16 lanes (512 bits).
- R6: Result lanes at or above the active lane count are zero in every masking mode.
- R7: With `mask_en` low, every active lane carries its converted value, whatever `lane_mask` and `zero_mode` hold.
- R8: With `mask_en` high and `zero_mode` low, an active lane whose `lane_mask` bit is 0 takes its value from the same lane of `prev_dst`.
- R9: With `mask_en` high and `zero_mode` high, an active lane whose `lane_mask` bit is 0 is zero.
- R10: `invalid_flag` is set by a signalling NaN (exponent 31, fraction nonzero, fraction bit 9 clear) on an active lane that is written. Quiet NaNs do not set it. Signalling NaNs on masked-off lanes or inactive lanes do not set it.
- R11: Once set, `invalid_flag` stays high until reset.
- R12: `result` and `out_valid` are registered. One cycle after `in_valid` is sampled high, `out_valid` is high and `result` holds that input's conversion. `out_valid` is low in any cycle not preceded by `in_valid`, and `result` holds its value then.
- R13: After reset, `out_valid`, `result` and `invalid_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept one conversion this cycle |
| src | input | 256 | Sixteen packed binary16 values, lane j at [16j+15:16j] |
| prev_dst | input | 512 | Previous destination contents used by merge masking |
| lane_mask | input | 16 | Per-lane write enable, bit j for lane j |
| mask_en | input | 1 | 1 applies `lane_mask`, 0 writes every active lane |
| zero_mode | input | 1 | 1 zeroes masked-off lanes, 0 merges from `prev_dst` |
| vlen_sel | input | 2 | Vector length: 0 = 128, 1 = 256, 2 or 3 = 512 bits |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 512 | Sixteen packed binary32 values, lane j at [32j+31:32j] |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
Every one of the 65536 binary16 encodings passes through the converter unmasked at full length. A reference built from real arithmetic checks each one, so one sweep separates the normal, zero, infinity, subnormal and NaN paths and catches an exponent or shift error in any lane position. Fixed mask patterns are applied under every combination of mask enable, merge or zero mode and all four length codes. These cases tell a merged lane from a zeroed lane from an out-of-range lane. Targeted NaN stimulus places signalling NaNs on masked-off lanes, on inactive lanes, as quiet NaNs, and finally on a written lane. This shows that only the last case sets the flag, and that the flag then survives later clean operations until reset. Back-to-back and isolated inputs check the valid timing and that the result holds between operations.

// File: rtl/fp16w_pkg.sv
package fp16w_pkg;

    localparam int HALF_W      = 16;
    localparam int HALF_EXP_W  = 5;
    localparam int HALF_FRAC_W = 10;
    localparam int SGL_W       = 32;
    localparam int SGL_EXP_W   = 8;
    localparam int SGL_FRAC_W  = 23;
    localparam int FRAC_PAD    = SGL_FRAC_W - HALF_FRAC_W;
    localparam int BIAS_ADJ    = 112;
    localparam int SHIFT_W     = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } cvt_state_e;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_512B = 2'd3
    } vlen_e;

    typedef struct packed {
        logic                   sign;
        logic [SGL_EXP_W-1:0]   exp;
        logic [SGL_FRAC_W-1:0]  frac;
    } sgl_t;

endpackage

// File: rtl/fp16w_lane_cvt.sv
module fp16w_lane_cvt
    import fp16w_pkg::*;
(
    input  logic [HALF_W-1:0] half_in,
    output logic [SGL_W-1:0]  sgl_out,
    output logic              is_snan
);

    logic                   sgn;
    logic [HALF_EXP_W-1:0]  hexp;
    logic [HALF_FRAC_W-1:0] hfrac;
    logic [SHIFT_W-1:0]     lshift;
    logic                   lead_found;
    logic [HALF_FRAC_W:0]   normed;
    sgl_t                   res;

    assign sgn   = half_in[HALF_W-1];
    assign hexp  = half_in[HALF_W-2 -: HALF_EXP_W];
    assign hfrac = half_in[HALF_FRAC_W-1:0];

    // distance that brings the leading one of a subnormal fraction to the hidden-bit position
    always_comb begin
        lshift     = '0;
        lead_found = 1'b0;
        for (int i = HALF_FRAC_W - 1; i >= 0; i--) begin
            if (!lead_found && hfrac[i]) begin
                lshift     = SHIFT_W'(HALF_FRAC_W - i);
                lead_found = 1'b1;
            end
        end
    end

    assign normed = {1'b0, hfrac} << lshift;

    always_comb begin
        res.sign = sgn;
        res.exp  = '0;
        res.frac = '0;
        if (hexp == '0) begin
            if (hfrac != '0) begin
                res.exp  = SGL_EXP_W'(BIAS_ADJ + 1) - SGL_EXP_W'(lshift);
                res.frac = {normed[HALF_FRAC_W-1:0], {FRAC_PAD{1'b0}}};
            end
        end else if (hexp == '1) begin
            res.exp = '1;
            if (hfrac != '0) begin
                res.frac = {1'b1, hfrac[HALF_FRAC_W-2:0], {FRAC_PAD{1'b0}}};
            end
        end else begin
            res.exp  = SGL_EXP_W'(hexp) + SGL_EXP_W'(BIAS_ADJ);
            res.frac = {hfrac, {FRAC_PAD{1'b0}}};
        end
    end

    assign sgl_out = res;
    assign is_snan = (hexp == '1) && (hfrac != '0) && !hfrac[HALF_FRAC_W-1];

endmodule

// File: rtl/fp16w_lane_sel.sv
module fp16w_lane_sel
    import fp16w_pkg::*;
(
    input  logic [SGL_W-1:0] conv,
    input  logic [SGL_W-1:0] prev,
    input  logic             active,
    input  logic             mask_bit,
    input  logic             mask_en,
    input  logic             zero_mode,
    input  logic             snan,
    output logic [SGL_W-1:0] word,
    output logic             raise
);

    logic written;
    logic keep_old;

    assign written  = active && (!mask_en || mask_bit);
    assign keep_old = active && mask_en && !mask_bit && !zero_mode;

    always_comb begin
        if (written) begin
            word = conv;
        end else if (keep_old) begin
            word = prev;
        end else begin
            word = '0;
        end
    end

    assign raise = written && snan;

endmodule

// File: rtl/fp16w_len_dec.sv
module fp16w_len_dec
    import fp16w_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [1:0]       vlen_sel,
    output logic [LANES-1:0] active
);

    localparam int LANES_128 = 128 / SGL_W;
    localparam int LANES_256 = 256 / SGL_W;

    int limit;

    always_comb begin
        unique case (vlen_e'(vlen_sel))
            VL_128:  limit = LANES_128;
            VL_256:  limit = LANES_256;
            VL_512,
            VL_512B: limit = LANES;
        endcase
    end

    for (genvar j = 0; j < LANES; j++) begin : g_act
        assign active[j] = (j < limit);
    end

endmodule

// File: rtl/fp16_widen_unit.sv
module fp16_widen_unit
    import fp16w_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*HALF_W-1:0] src,
    input  logic [LANES*SGL_W-1:0]  prev_dst,
    input  logic [LANES-1:0]        lane_mask,
    input  logic                    mask_en,
    input  logic                    zero_mode,
    input  logic [1:0]              vlen_sel,
    output logic                    out_valid,
    output logic [LANES*SGL_W-1:0]  result,
    output logic                    invalid_flag
);

    localparam int DST_W = LANES * SGL_W;

    cvt_state_e         state_q;
    cvt_state_e         state_d;
    logic [LANES-1:0]   active;
    logic [LANES-1:0]   lane_raise;
    logic [DST_W-1:0]   packed_d;
    logic [DST_W-1:0]   result_q;
    logic               flag_q;

    fp16w_len_dec #(.LANES(LANES)) u_len (
        .vlen_sel (vlen_sel),
        .active   (active)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [SGL_W-1:0] conv;
        logic             snan;

        fp16w_lane_cvt u_cvt (
            .half_in (src[j*HALF_W +: HALF_W]),
            .sgl_out (conv),
            .is_snan (snan)
        );

        fp16w_lane_sel u_sel (
            .conv      (conv),
            .prev      (prev_dst[j*SGL_W +: SGL_W]),
            .active    (active[j]),
            .mask_bit  (lane_mask[j]),
            .mask_en   (mask_en),
            .zero_mode (zero_mode),
            .snan      (snan),
            .word      (packed_d[j*SGL_W +: SGL_W]),
            .raise     (lane_raise[j])
        );
    end

    // transitions T_WAIT, T_ACCEPT, T_CHAIN, T_RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            flag_q   <= 1'b0;
        end else if (in_valid) begin
            result_q <= packed_d;
            flag_q   <= flag_q | (|lane_raise);
        end
    end

    assign out_valid    = (state_q == ST_EMIT);
    assign result       = result_q;
    assign invalid_flag = flag_q;

endmodule

// File: rtl/fp16w_checker.sv
module fp16w_checker #(
    parameter int DST_W = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       vlen_sel,
    input logic             mask_en,
    input logic             zero_mode,
    input logic             mask0,
    input logic [31:0]      prev_lo,
    input logic             out_valid,
    input logic [DST_W-1:0] result,
    input logic             invalid_flag
);

    assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_flag |=> invalid_flag);

    assert_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(invalid_flag) |-> $past(in_valid));

    assert_upper_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'd0) |=> (result[DST_W-1:128] == '0));

    assert_merge_lane0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && !zero_mode && !mask0) |=> (result[31:0] == $past(prev_lo)));

    assert_zero_lane0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && zero_mode && !mask0) |=> (result[31:0] == 32'd0));

endmodule

bind fp16_widen_unit fp16w_checker #(.DST_W(LANES * 32)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .vlen_sel     (vlen_sel),
    .mask_en      (mask_en),
    .zero_mode    (zero_mode),
    .mask0        (lane_mask[0]),
    .prev_lo      (prev_dst[31:0]),
    .out_valid    (out_valid),
    .result       (result),
    .invalid_flag (invalid_flag)
);

// File: tb/tb_fp16_widen_unit.sv
module tb_fp16_widen_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [255:0] src = '0;
    logic [511:0] prev_dst = '0;
    logic [15:0]  lane_mask = '0;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic [1:0]   vlen_sel = 2'd2;
    logic         out_valid;
    logic [511:0] result;
    logic         invalid_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    fp16_widen_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
        .prev_dst(prev_dst), .lane_mask(lane_mask), .mask_en(mask_en),
        .zero_mode(zero_mode), .vlen_sel(vlen_sel), .out_valid(out_valid),
        .result(result), .invalid_flag(invalid_flag)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] ref_cvt(input logic [15:0] h);
        int  e = int'(h[14:10]);
        int  f = int'(h[9:0]);
        real v;
        logic [63:0] d;
        logic [10:0] de;
        if (e == 31)
            return (f == 0) ? {h[15], 8'hFF, 23'h0} : {h[15], 8'hFF, 1'b1, h[8:0], 13'h0};
        if (e == 0 && f == 0)
            return {h[15], 31'h0};
        if (e == 0) v = real'(f) * (2.0 ** (-24));
        else        v = (1.0 + real'(f) / 1024.0) * (2.0 ** (e - 15));
        d  = $realtobits(v);
        de = d[62:52] - 11'd896;
        return {h[15], de[7:0], d[51:29]};
    endfunction

    function automatic logic [511:0] ref_vec(input logic [255:0] s, input logic [511:0] p,
                                             input logic [15:0] m, input logic men,
                                             input logic zm, input logic [1:0] vl);
        logic [511:0] r = '0;
        int n = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
        for (int j = 0; j < 16; j++) begin
            if (j < n) begin
                if (!men || m[j]) r[j*32 +: 32] = ref_cvt(s[j*16 +: 16]);
                else if (!zm)     r[j*32 +: 32] = p[j*32 +: 32];
            end
        end
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // one operation: drive, sample the registered result, then confirm it holds
    task automatic run_op(input string tag, input logic [255:0] s, input logic [511:0] p,
                          input logic [15:0] m, input logic men, input logic zm,
                          input logic [1:0] vl);
        logic [511:0] exp = ref_vec(s, p, m, men, zm, vl);
        @(negedge clk);
        src = s; prev_dst = p; lane_mask = m; mask_en = men; zero_mode = zm; vlen_sel = vl;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        src = ~s; prev_dst = ~p;
        check_bit({tag, " out_valid R12"}, out_valid, 1'b1);
        check_vec(tag, result, exp);
        @(negedge clk);
        check_bit({tag, " valid drop R12"}, out_valid, 1'b0);
        check_vec({tag, " hold R12"}, result, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    logic [255:0] mix_src;
    logic [511:0] mix_prev;

    initial begin
        for (int j = 0; j < 16; j++) mix_prev[j*32 +: 32] = 32'hC0DE0000 + 32'(j * 257);
        mix_src = {16'h3C00, 16'h0001, 16'h8000, 16'h7C00, 16'hFC00, 16'h7E55, 16'h03FF, 16'h7BFF,
                   16'h0400, 16'hC500, 16'h0200, 16'h8155, 16'h3555, 16'h0000, 16'hFE01, 16'h4248};

        do_reset();
        // R13 reset state
        check_bit("R13 out_valid", out_valid, 1'b0);
        check_vec("R13 result", result, '0);
        check_bit("R13 invalid_flag", invalid_flag, 1'b0);

        // R10: sNaN masked off, sNaN beyond length, quiet NaNs: flag stays clear
        run_op("R10 masked snan", {240'h0, 16'h7C01}, mix_prev, 16'hFFFE, 1'b1, 1'b0, 2'd2);
        check_bit("R10 masked snan flag", invalid_flag, 1'b0);
        run_op("R10 inactive snan", {112'h0, 16'h7D00, 128'h0}, mix_prev, 16'hFFFF, 1'b0, 1'b0, 2'd0);
        check_bit("R10 inactive snan flag", invalid_flag, 1'b0);
        run_op("R10 qnan", {16{16'h7E01}}, mix_prev, 16'h0, 1'b0, 1'b0, 2'd2);
        check_bit("R10 qnan flag", invalid_flag, 1'b0);
        run_op("R10 written snan", {192'h0, 16'hFC02, 48'h0}, mix_prev, 16'h0008, 1'b1, 1'b1, 2'd0);
        check_bit("R10 written snan flag", invalid_flag, 1'b1);
        // R11 sticky through clean operations
        run_op("R11 clean op", mix_src & {16{16'h3FFF}}, mix_prev, 16'h0, 1'b0, 1'b0, 2'd2);
        check_bit("R11 flag held", invalid_flag, 1'b1);
        do_reset();
        check_bit("R11 flag cleared by reset", invalid_flag, 1'b0);

        // R5 R6 R7 R8 R9: masking and length over all combinations
        for (int vl = 0; vl < 4; vl++) begin
            for (int men = 0; men < 2; men++) begin
                for (int zm = 0; zm < 2; zm++) begin
                    run_op("R5 R6 R7 R8 R9 mask mix", mix_src, mix_prev, 16'hA5C3,
                           men[0], zm[0], vl[1:0]);
                    run_op("R6 R8 R9 mask none", mix_src, mix_prev, 16'h0000,
                           men[0], zm[0], vl[1:0]);
                end
            end
        end

        // R12 back to back inputs
        @(negedge clk);
        src = mix_src; prev_dst = mix_prev; mask_en = 1'b0; vlen_sel = 2'd2; in_valid = 1'b1;
        @(negedge clk);
        src = {16{16'h4000}};
        check_bit("R12 first valid", out_valid, 1'b1);
        check_vec("R12 first result", result, ref_vec(mix_src, mix_prev, 16'h0, 1'b0, 1'b0, 2'd2));
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R12 chained valid", out_valid, 1'b1);
        check_vec("R12 chained result", result, {16{32'h40000000}});
        @(negedge clk);
        check_bit("R12 idle after chain", out_valid, 1'b0);

        // R1 R2 R3 R4: every half encoding, sixteen per operation
        for (int b = 0; b < 4096; b++) begin
            logic [255:0] s;
            for (int j = 0; j < 16; j++) s[j*16 +: 16] = 16'(b * 16 + j);
            run_op("R1 R2 R3 R4 sweep", s, mix_prev, 16'h0, 1'b0, 1'b0, 2'd2);
        end
        check_bit("R10 sweep snan flag", invalid_flag, 1'b1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule